// File: doc/BRIEF.md
# Synchronous SRAM with Configurable Read Pipeline

A clocked single-port memory with a parameterized number of words, each made of several byte lanes. All commands are captured on the rising clock edge: a read, a write (global, or byte by byte), or a deselect when the chip select is low. Read data leaves through one of two paths, chosen at run time. In flow-through mode the registered address drives the storage directly. In pipelined mode one more output register follows.

The block drives a data-bus enable, `bus_oe`, that tells an outer pad ring when `rdata` may be placed on a shared bus. A second mode input sets how soon that enable drops after a deselect: with the same latency as read data (dual-cycle), or one stage sooner (single-cycle). The enable is gated at once by an asynchronous output enable and by a sleep input. Sleep also blocks commands while the stored contents are kept. Mode inputs are meant to be static. They change only after at least two idle cycles.

Top module: `ssram_cfgpipe`

## Requirements
- R1: A write takes effect only at a rising edge where `chip_sel` is high. With `chip_sel` low, the stored word is left unchanged.
- R2: In flow-through mode (`pipe_mode`=0), the word read by a command sampled at edge k appears on `rdata` right after edge k, with `bus_oe` high.
- R3: In pipelined mode (`pipe_mode`=1), the word read by a command sampled at edge k appears on `rdata` right after edge k+1, with `bus_oe` high when the command at edge k+1 is another read.
- R4: With `byte_wr_en`=1 and `global_wr`=0, only lanes whose `byte_sel` bit is set are written. Bit i selects `wdata[8i+7:8i]`.
- R5: With `global_wr`=1, every lane is written, whatever `byte_wr_en` and `byte_sel` are.
- R6: A write command with `global_wr`=0 and no `byte_sel` bit set changes no lane.
- R7: After any edge that samples a write command (`chip_sel`, plus `global_wr` or `byte_wr_en`), `bus_oe` is low in the following cycle, even if a pipelined read is still in flight.
- R8: In pipelined mode with `dual_desel`=1, a deselect sampled at edge k lets the previous read keep driving after edge k. `bus_oe` is low after edge k+1.
- R9: In pipelined mode with `dual_desel`=0, `bus_oe` is low right after the edge that samples a deselect. In flow-through mode this holds for both deselect settings.
- R10: `bus_oe` follows `out_en` without waiting for a clock edge. It is low whenever `out_en` is low.
- R11: `sleep`=1 forces `bus_oe` low at once. Commands sampled during sleep are treated as deselects, and stored data is kept.
- R12: A read of an address written at the previous edge returns the newly written word.
- R13: After reset, `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| chip_sel | input | 1 | Command select. Low means deselect |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| global_wr | input | 1 | Write all lanes |
| byte_wr_en | input | 1 | Byte-write enable |
| byte_sel | input | LANES | Per-lane write select |
| pipe_mode | input | 1 | 1 = pipelined read, 0 = flow-through |
| dual_desel | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| out_en | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep, blocks commands |
| rdata | output | LANES*LANE_W | Read data |
| bus_oe | output | 1 | Data-bus drive enable |

## Verification
In pipelined mode, a read still in flight and a newly captured write fall in the same cycle. The read's data reaches the output register at the same edge that captures the write. The bench provokes this with a read followed directly by a write, and expects `bus_oe` low in the next cycle even though the output register holds valid data. A second overlap, a deselect arriving while the previous read is still driving, is judged cycle by cycle in both deselect modes.

// File: rtl/ssram_pkg.sv
`timescale 1ns/1ps
package ssram_pkg;
   typedef enum logic [1:0] {
      OP_NOP   = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } ssram_op_e;
endpackage

// File: rtl/ssram_cmd_dec.sv
`timescale 1ns/1ps
module ssram_cmd_dec
   import ssram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             chip_sel,
   input  logic             sleep,
   input  logic             global_wr,
   input  logic             byte_wr_en,
   input  logic [LANES-1:0] byte_sel,
   output ssram_op_e        op,
   output logic [LANES-1:0] lane_we
);
   logic live;
   logic wr_cmd;

   assign live   = chip_sel && !sleep;
   assign wr_cmd = global_wr || byte_wr_en;

   always_comb begin
      op = OP_NOP;
      if (live) op = wr_cmd ? OP_WRITE : OP_READ;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_we
      assign lane_we[l] = live && (global_wr || (byte_wr_en && byte_sel[l]));
   end
endmodule

// File: rtl/ssram_lanes.sv
`timescale 1ns/1ps
module ssram_lanes #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic [LANES-1:0]        lane_we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rword
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];
      always_ff @(posedge clk) begin
         if (lane_we[l]) store[waddr] <= wdata[l*LANE_W +: LANE_W];
      end
      assign rword[l*LANE_W +: LANE_W] = store[raddr];
   end
endmodule

// File: rtl/ssram_rdpath.sv
`timescale 1ns/1ps
module ssram_rdpath
   import ssram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ssram_op_e         op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pipe_mode,
   input  logic              dual_desel,
   input  logic              out_en,
   input  logic              sleep,
   input  logic [DATA_W-1:0] rword,
   output logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              bus_oe
);
   ssram_op_e         s1_op;
   logic              s2_rd;
   logic [DATA_W-1:0] dout_q;
   logic              live_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_op <= OP_NOP;
         s2_rd <= 1'b0;
      end else begin
         s1_op <= op;
         s2_rd <= (s1_op == OP_READ);
      end
   end

   always_ff @(posedge clk) begin
      if (op == OP_READ) raddr <= addr;
      if (s1_op == OP_READ) dout_q <= rword;
   end

   always_comb begin
      if (pipe_mode)
         live_sel = s2_rd && (dual_desel || (s1_op != OP_NOP));
      else
         live_sel = (s1_op == OP_READ);
   end

   assign bus_oe = out_en && !sleep && (s1_op != OP_WRITE) && live_sel;
   assign rdata  = pipe_mode ? dout_q : rword;
endmodule

// File: rtl/ssram_cfgpipe.sv
`timescale 1ns/1ps
module ssram_cfgpipe
   import ssram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chip_sel,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    global_wr,
   input  logic                    byte_wr_en,
   input  logic [LANES-1:0]        byte_sel,
   input  logic                    pipe_mode,
   input  logic                    dual_desel,
   input  logic                    out_en,
   input  logic                    sleep,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    bus_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ssram_cfgpipe: ADDR_W out of range");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("ssram_cfgpipe: lane geometry must be positive");
   end

   ssram_op_e         op;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] raddr;
   logic [DATA_W-1:0] rword;

   ssram_cmd_dec #(.LANES(LANES)) u_dec (
      .chip_sel   (chip_sel),
      .sleep      (sleep),
      .global_wr  (global_wr),
      .byte_wr_en (byte_wr_en),
      .byte_sel   (byte_sel),
      .op         (op),
      .lane_we    (lane_we)
   );

   ssram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .clk     (clk),
      .lane_we (lane_we),
      .waddr   (addr),
      .wdata   (wdata),
      .raddr   (raddr),
      .rword   (rword)
   );

   ssram_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .addr       (addr),
      .pipe_mode  (pipe_mode),
      .dual_desel (dual_desel),
      .out_en     (out_en),
      .sleep      (sleep),
      .rword      (rword),
      .raddr      (raddr),
      .rdata      (rdata),
      .bus_oe     (bus_oe)
   );
endmodule

// File: rtl/ssram_cfgpipe_chk.sv
`timescale 1ns/1ps
module ssram_cfgpipe_chk #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    chip_sel,
   input logic [ADDR_W-1:0]       addr,
   input logic [LANES*LANE_W-1:0] wdata,
   input logic                    global_wr,
   input logic                    byte_wr_en,
   input logic                    pipe_mode,
   input logic                    dual_desel,
   input logic                    out_en,
   input logic                    sleep,
   input logic [LANES*LANE_W-1:0] rdata,
   input logic                    bus_oe
);
   logic desel;
   assign desel = !chip_sel || sleep;

   assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (out_en && !sleep));

   assert_wr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_sel && !sleep && (global_wr || byte_wr_en)) |=> !bus_oe);

   assert_scd_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (desel && (!pipe_mode || !dual_desel)) |=> !bus_oe);

   assert_dcd_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (desel && pipe_mode && dual_desel) |=> ##1 !bus_oe);

   assert_fwd_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_sel && !sleep && global_wr) ##1
      (chip_sel && !sleep && !global_wr && !byte_wr_en && !pipe_mode && addr == $past(addr))
      |=> (rdata == $past(wdata, 2)));
endmodule

bind ssram_cfgpipe ssram_cfgpipe_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_sel   (chip_sel),
   .addr       (addr),
   .wdata      (wdata),
   .global_wr  (global_wr),
   .byte_wr_en (byte_wr_en),
   .pipe_mode  (pipe_mode),
   .dual_desel (dual_desel),
   .out_en     (out_en),
   .sleep      (sleep),
   .rdata      (rdata),
   .bus_oe     (bus_oe)
);

// File: tb/ssram_cfgpipe_bench.sv
`timescale 1ns/1ps
module ssram_cfgpipe_bench;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          chip_sel, global_wr, byte_wr_en, pipe_mode, dual_desel, out_en, sleep;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [NL-1:0] byte_sel;
   logic [DW-1:0] rdata;
   logic          bus_oe;

   int errors = 0;
   int checks = 0;
   logic [DW-1:0] model [1<<AW];

   always #2.5 clk = ~clk;

   ssram_cfgpipe #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) u_ssram_cfgpipe (
      .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .addr(addr), .wdata(wdata),
      .global_wr(global_wr), .byte_wr_en(byte_wr_en), .byte_sel(byte_sel),
      .pipe_mode(pipe_mode), .dual_desel(dual_desel), .out_en(out_en), .sleep(sleep),
      .rdata(rdata), .bus_oe(bus_oe)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      chip_sel = 0; global_wr = 0; byte_wr_en = 0; byte_sel = '0;
   endtask

   task automatic set_mode(input logic p, input logic d);
      idle(); cyc(); cyc();
      pipe_mode = p; dual_desel = d;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic g, input logic b, input logic [NL-1:0] s, input logic cs);
      chip_sel = cs; addr = a; wdata = d; global_wr = g; byte_wr_en = b; byte_sel = s;
      if (cs && !sleep) begin
         if (g) model[a] = d;
         else if (b)
            for (int l = 0; l < NL; l++)
               if (s[l]) model[a][l*8 +: 8] = d[l*8 +: 8];
      end
      cyc();
      idle();
   endtask

   task automatic rd_cmd(input logic [AW-1:0] a);
      chip_sel = 1; addr = a; global_wr = 0; byte_wr_en = 0; byte_sel = '0;
   endtask

   task automatic read_flow(input logic [AW-1:0] a, input string req);
      rd_cmd(a); cyc();
      check(req, rdata, model[a]);
      check(req, {31'd0, bus_oe}, 1);
      idle();
   endtask

   task automatic read_pipe(input logic [AW-1:0] a, input string req);
      rd_cmd(a); cyc(); cyc();
      check(req, rdata, model[a]);
      check(req, {31'd0, bus_oe}, 1);
      idle();
   endtask

   // R13: reset state
   task automatic t_reset();
      check("R13", {31'd0, bus_oe}, 0);
   endtask

   // R2, R12 flow-through reads and forwarding
   task automatic t_flow();
      set_mode(0, 0);
      for (int i = 0; i < 4; i++) begin
         do_write(AW'(i), 32'hA5000000 + DW'(i * 32'h1111), 1, 0, '0, 1);
         read_flow(AW'(i), "R12");
      end
      for (int i = 3; i >= 0; i--) read_flow(AW'(i), "R2");
   endtask

   // R3 pipelined reads, back to back
   task automatic t_pipe();
      set_mode(1, 0);
      do_write(6'd10, 32'h0BADF00D, 1, 0, '0, 1);
      read_pipe(6'd10, "R12");
      do_write(6'd11, 32'h12345678, 1, 0, '0, 1);
      rd_cmd(6'd10); cyc();
      rd_cmd(6'd11); cyc();
      check("R3", rdata, model[10]);
      rd_cmd(6'd11); cyc();
      check("R3", rdata, model[11]);
      check("R3", {31'd0, bus_oe}, 1);
      idle();
   endtask

   // R4, R5, R6, R1 byte lanes, global write, no-op writes, chip select
   task automatic t_lanes();
      set_mode(0, 0);
      do_write(6'd20, 32'h11223344, 1, 0, '0, 1);
      do_write(6'd20, 32'hAABBCCDD, 0, 1, 4'b0101, 1);
      read_flow(6'd20, "R4");
      check("R4", rdata, 32'h11BB33DD);
      do_write(6'd20, 32'hFFFFFFFF, 0, 1, 4'b0000, 1);
      read_flow(6'd20, "R6");
      check("R6", rdata, 32'h11BB33DD);
      do_write(6'd20, 32'hCAFEBABE, 1, 1, 4'b0010, 1);
      read_flow(6'd20, "R5");
      check("R5", rdata, 32'hCAFEBABE);
      do_write(6'd20, 32'h55555555, 1, 1, 4'b1111, 0);
      read_flow(6'd20, "R1");
      check("R1", rdata, 32'hCAFEBABE);
   endtask

   // R7 write turns the bus off, including a pipelined read in flight
   task automatic t_wr_oe();
      set_mode(0, 0);
      rd_cmd(6'd0); cyc();
      check("R7", {31'd0, bus_oe}, 1);
      do_write(6'd30, 32'h01020304, 1, 0, '0, 1);
      check("R7", {31'd0, bus_oe}, 0);
      set_mode(1, 1);
      rd_cmd(6'd0); cyc();
      do_write(6'd31, 32'h0A0B0C0D, 0, 1, 4'b1000, 1);
      check("R7", {31'd0, bus_oe}, 0);
      check("R7", rdata, model[0]);
   endtask

   // R8, R9 deselect timing
   task automatic t_desel();
      set_mode(1, 1);
      rd_cmd(6'd1); cyc();
      idle(); cyc();
      check("R8", {31'd0, bus_oe}, 1);
      check("R8", rdata, model[1]);
      cyc();
      check("R8", {31'd0, bus_oe}, 0);
      set_mode(1, 0);
      rd_cmd(6'd1); cyc();
      idle(); cyc();
      check("R9", {31'd0, bus_oe}, 0);
      set_mode(0, 1);
      rd_cmd(6'd2); cyc();
      check("R9", {31'd0, bus_oe}, 1);
      idle(); cyc();
      check("R9", {31'd0, bus_oe}, 0);
   endtask

   // R10 asynchronous output enable
   task automatic t_oe();
      set_mode(0, 0);
      rd_cmd(6'd3); cyc();
      #0.5 out_en = 0; #0.3;
      check("R10", {31'd0, bus_oe}, 0);
      #0.2 out_en = 1; #0.3;
      check("R10", {31'd0, bus_oe}, 1);
      idle();
   endtask

   // R11 sleep
   task automatic t_sleep();
      set_mode(0, 0);
      do_write(6'd40, 32'hDEADBEEF, 1, 0, '0, 1);
      rd_cmd(6'd40); cyc();
      #0.5 sleep = 1; #0.3;
      check("R11", {31'd0, bus_oe}, 0);
      idle();
      do_write(6'd40, 32'h00000000, 1, 0, '0, 1);
      rd_cmd(6'd40); cyc();
      check("R11", {31'd0, bus_oe}, 0);
      idle(); cyc();
      sleep = 0;
      read_flow(6'd40, "R11");
      check("R11", rdata, 32'hDEADBEEF);
   endtask

   initial begin
      #100000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 0; idle(); addr = '0; wdata = '0;
      pipe_mode = 1; dual_desel = 0; out_en = 1; sleep = 0;
      cyc(); cyc(); cyc();
      t_reset();
      rst_n = 1;
      cyc();
      t_flow();
      t_pipe();
      t_lanes();
      t_wr_oe();
      t_desel();
      t_oe();
      t_sleep();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule